// File: doc/BRIEF.md
# Address-Filtering Receive Stage with Overflow Discard

This stage sits on the input link of a network node. Each packet starts with a header word. The stage reads the header's destination field and compares it with the node's own address. A packet addressed to this node goes into a local input buffer, where the attached function block reads it. Every other packet goes into a forwarding buffer that feeds the node's output side.

The local buffer only ever presents complete packets. Words of a local packet are written speculatively. The packet becomes visible to the reader only once its last word has been stored. If the buffer runs out of room partway through a packet, the words already written are taken back out. The rest of the packet is swallowed, and the stage produces a single-word resend request addressed to the packet's sender. A local packet that fills the buffer is therefore never held back by throttling the link. The forwarding buffer is an ordinary first-in first-out queue with no discard or resend.

Word layout, with the default 16-bit width:

| Bits | Header word content |
|------|---------------------|
| [15:12] | destination address |
| [11:8] | source address |
| [7:6] | opcode (`2'b11` = resend request) |
| [5:0] | free for the sender |

Payload words are never decoded. The `last` flag marks the final word of a packet.

Top module: `rx_filter_stage`

## Requirements
- R1: A packet whose header bits [15:12] equal `node_addr` is written, in full and in order, to the local buffer. Each word keeps its `last` flag.
- R2: A packet whose header destination differs from `node_addr` is written in order to the forwarding buffer. Its payload words are never decoded, so a payload word that looks like a local header still stays on the forwarding path.
- R3: No word of a local packet shows on the local read port (`loc_vld` stays 0) before that packet's last word has been accepted.
- R4: A local word fits only if the local buffer is not full at the start of its cycle. With no reads, p stored words and a new packet of L words give a kept packet exactly when p+L ≤ depth (8). Otherwise every word of the new packet is removed, and earlier packets stay intact.
- R5: After an overflow, the remaining words of that packet, up to and including the one flagged `last`, are accepted and dropped. The next word is decoded as a fresh header.
- R6: An overflow produces one resend word. It carries the dropped packet's source address in bits [15:12], `node_addr` in bits [11:8], opcode `2'b11` in bits [7:6] and zero in bits [5:0]. It is held stable on `rs_data` until `rs_rdy` takes it.
- R7: A local packet whose header opcode is `2'b11` is dropped on overflow without producing a resend word.
- R8: `lnk_rdy` is low while the forwarding buffer is full or a resend word is waiting. A word offered while `lnk_rdy` is low is not taken.
- R9: After reset `lnk_rdy` is 1 and `loc_vld`, `byp_vld` and `rs_vld` are 0.
- R10: A read from a full local buffer in the same cycle as a local word arrives does not save that word. The packet is still dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| node_addr | input | AW (4) | Address of this node |
| lnk_vld | input | 1 | Link word valid |
| lnk_rdy | output | 1 | Stage can take a link word |
| lnk_data | input | DW (16) | Link word |
| lnk_last | input | 1 | Link word ends its packet |
| loc_vld | output | 1 | Committed local word available |
| loc_rdy | input | 1 | Local reader takes the word |
| loc_data | output | DW (16) | Local word |
| loc_last | output | 1 | Local word ends its packet |
| byp_vld | output | 1 | Forwarding word available |
| byp_rdy | input | 1 | Output side takes the word |
| byp_data | output | DW (16) | Forwarding word |
| byp_last | output | 1 | Forwarding word ends its packet |
| rs_vld | output | 1 | Resend word available |
| rs_rdy | input | 1 | Resend word taken |
| rs_data | output | DW (16) | Resend word |

## Verification
An overflow rollback and a read from the local buffer can happen in the same clock. The bench provokes this by filling the local buffer to its depth and then raising `loc_rdy` at the edge where a new local header arrives. It judges the outcome as follows: the resend word must name the new packet's sender, the reader must receive exactly the earlier words, and the following word of the dropped packet must be swallowed even though a slot is now free. A sweep over every starting occupancy and packet length checks the fit boundary the same way.

// File: rtl/rx_pkg.sv
// Shared types for the receive stage.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rx_pkg;

    // Routing state of the packet currently on the link.
    typedef enum logic [1:0] {
        ST_HEAD  = 2'd0,   // next word is a header
        ST_LOCAL = 2'd1,   // body of a packet kept locally
        ST_PASS  = 2'd2,   // body of a forwarded packet
        ST_DROP  = 2'd3    // body of a discarded packet
    } rx_state_e;

endpackage

// File: rtl/rx_commit_fifo.sv
// Local input buffer with speculative and committed write pointers.
// Words are written at the speculative pointer. The committed pointer moves
// when the last word of a packet is written, and only committed words are
// readable. A drop rewinds the speculative pointer to the committed one.
// Assumes: DEPTH is a power of two; push and drop never coincide; push is
// never raised while full.
module rx_commit_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_last,
    input  logic          drop,
    output logic          full,
    input  logic          pop,
    output logic          out_vld,
    output logic [DW-1:0] out_data,
    output logic          out_last
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] CAP = (PW+1)'(DEPTH);

    logic [DW:0] mem [DEPTH];
    logic [PW:0] wr_spec;
    logic [PW:0] wr_cmt;
    logic [PW:0] rd;

    assign full     = (wr_spec - rd) == CAP;
    assign out_vld  = (wr_cmt != rd);
    assign out_data = mem[rd[PW-1:0]][DW-1:0];
    assign out_last = mem[rd[PW-1:0]][DW];

    // Store an incoming word at the speculative slot.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_spec[PW-1:0]] <= {push_last, push_data};
        end
    end

    // Move the speculative, committed and read pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_spec <= '0;
            wr_cmt  <= '0;
            rd      <= '0;
        end else begin
            if (drop) begin
                wr_spec <= wr_cmt;
            end else if (push) begin
                wr_spec <= wr_spec + 1'b1;
                if (push_last) begin
                    wr_cmt <= wr_spec + 1'b1;
                end
            end
            if (pop && out_vld) begin
                rd <= rd + 1'b1;
            end
        end
    end

    a_r3_commit_within_spec: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmt - rd) <= (wr_spec - rd));
    a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r4_drop_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (wr_spec == wr_cmt));

endmodule

// File: rtl/rx_plain_fifo.sv
// Forwarding buffer: ordinary first-in first-out queue of words with their
// last flag. It has no discard and no resend.
// Assumes: DEPTH is a power of two; push is never raised while full.
module rx_plain_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_last,
    output logic          full,
    input  logic          pop,
    output logic          out_vld,
    output logic [DW-1:0] out_data,
    output logic          out_last
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] CAP = (PW+1)'(DEPTH);

    logic [DW:0] mem [DEPTH];
    logic [PW:0] wr;
    logic [PW:0] rd;

    assign full     = (wr - rd) == CAP;
    assign out_vld  = (wr != rd);
    assign out_data = mem[rd[PW-1:0]][DW-1:0];
    assign out_last = mem[rd[PW-1:0]][DW];

    // Store an incoming word at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr[PW-1:0]] <= {push_last, push_data};
        end
    end

    // Advance the write and read pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr <= '0;
            rd <= '0;
        end else begin
            if (push) begin
                wr <= wr + 1'b1;
            end
            if (pop && out_vld) begin
                rd <= rd + 1'b1;
            end
        end
    end

    a_r2_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/rx_route_ctrl.sv
// Routing and overflow control. Decodes each header, picks the local or the
// forwarding path, watches the local buffer for overflow, swallows the rest
// of a dropped packet and builds the single-word resend request.
// Assumes: the header fields come from the word on the link; a header with
// opcode all-ones is itself a resend request and is never answered.
module rx_route_ctrl
    import rx_pkg::*;
#(
    parameter int DW  = 16,
    parameter int AW  = 4,
    parameter int OPW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] node_addr,
    input  logic          lnk_vld,
    input  logic          lnk_last,
    input  logic [AW-1:0] hdr_dst,
    input  logic [AW-1:0] hdr_src,
    input  logic [OPW-1:0] hdr_op,
    output logic          lnk_rdy,
    input  logic          loc_full,
    input  logic          byp_full,
    output logic          loc_push,
    output logic          loc_drop,
    output logic          byp_push,
    output logic          rs_vld,
    input  logic          rs_rdy,
    output logic [DW-1:0] rs_data
);
    localparam int PADW = DW - 2*AW - OPW;
    localparam logic [OPW-1:0] OP_RESEND = '1;

    rx_state_e      state, state_nxt;
    logic [AW-1:0]  keep_src;
    logic [OPW-1:0] keep_op;
    logic [AW-1:0]  rs_src;
    logic [OPW-1:0] rs_op;
    logic           accept;
    logic           overflow;
    logic           rs_make;

    assign lnk_rdy = !byp_full && !rs_vld;
    assign accept  = lnk_vld && lnk_rdy;
    assign rs_make = overflow && (rs_op != OP_RESEND);

    // Choose the path for the accepted word and detect overflow.
    always_comb begin
        state_nxt = state;
        loc_push  = 1'b0;
        byp_push  = 1'b0;
        overflow  = 1'b0;
        rs_src    = keep_src;
        rs_op     = keep_op;
        if (accept) begin
            unique case (state)
                ST_HEAD: begin
                    rs_src = hdr_src;
                    rs_op  = hdr_op;
                    if (hdr_dst == node_addr) begin
                        if (loc_full) begin
                            overflow  = 1'b1;
                            state_nxt = lnk_last ? ST_HEAD : ST_DROP;
                        end else begin
                            loc_push  = 1'b1;
                            state_nxt = lnk_last ? ST_HEAD : ST_LOCAL;
                        end
                    end else begin
                        byp_push  = 1'b1;
                        state_nxt = lnk_last ? ST_HEAD : ST_PASS;
                    end
                end
                ST_LOCAL: begin
                    if (loc_full) begin
                        overflow  = 1'b1;
                        state_nxt = lnk_last ? ST_HEAD : ST_DROP;
                    end else begin
                        loc_push  = 1'b1;
                        state_nxt = lnk_last ? ST_HEAD : ST_LOCAL;
                    end
                end
                ST_PASS: begin
                    byp_push  = 1'b1;
                    state_nxt = lnk_last ? ST_HEAD : ST_PASS;
                end
                default: begin
                    state_nxt = lnk_last ? ST_HEAD : ST_DROP;
                end
            endcase
        end
    end

    assign loc_drop = overflow;

    // Hold the routing state and the header fields of the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HEAD;
            keep_src <= '0;
            keep_op  <= '0;
        end else begin
            state <= state_nxt;
            if (accept && state == ST_HEAD) begin
                keep_src <= hdr_src;
                keep_op  <= hdr_op;
            end
        end
    end

    // Build and hold the resend word until the output side takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_vld  <= 1'b0;
            rs_data <= '0;
        end else if (rs_make) begin
            rs_vld  <= 1'b1;
            rs_data <= {rs_src, node_addr, OP_RESEND, {PADW{1'b0}}};
        end else if (rs_vld && rs_rdy) begin
            rs_vld  <= 1'b0;
        end
    end

    a_r6_resend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_vld && !rs_rdy) |=> (rs_vld && $stable(rs_data)));
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        rs_make |-> !rs_vld);
    a_r5_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({loc_push, byp_push, loc_drop}) <= 1);

endmodule

// File: rtl/rx_filter_stage.sv
// Top of the receive stage: address filter, local commit buffer,
// forwarding buffer and resend generator.
// Assumes: header layout is destination in the top AW bits, source in the
// next AW bits, then an OPW-bit opcode; both depths are powers of two.
module rx_filter_stage #(
    parameter int DW        = 16,
    parameter int AW        = 4,
    parameter int OPW       = 2,
    parameter int LOC_DEPTH = 8,
    parameter int BYP_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] node_addr,
    input  logic          lnk_vld,
    output logic          lnk_rdy,
    input  logic [DW-1:0] lnk_data,
    input  logic          lnk_last,
    output logic          loc_vld,
    input  logic          loc_rdy,
    output logic [DW-1:0] loc_data,
    output logic          loc_last,
    output logic          byp_vld,
    input  logic          byp_rdy,
    output logic [DW-1:0] byp_data,
    output logic          byp_last,
    output logic          rs_vld,
    input  logic          rs_rdy,
    output logic [DW-1:0] rs_data
);
    localparam int DST_LO = DW - AW;
    localparam int SRC_LO = DW - 2*AW;
    localparam int OP_LO  = SRC_LO - OPW;

    logic loc_push, loc_drop, loc_full;
    logic byp_push, byp_full;

    rx_route_ctrl #(.DW(DW), .AW(AW), .OPW(OPW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .node_addr(node_addr),
        .lnk_vld  (lnk_vld),
        .lnk_last (lnk_last),
        .hdr_dst  (lnk_data[DW-1:DST_LO]),
        .hdr_src  (lnk_data[DST_LO-1:SRC_LO]),
        .hdr_op   (lnk_data[SRC_LO-1:OP_LO]),
        .lnk_rdy  (lnk_rdy),
        .loc_full (loc_full),
        .byp_full (byp_full),
        .loc_push (loc_push),
        .loc_drop (loc_drop),
        .byp_push (byp_push),
        .rs_vld   (rs_vld),
        .rs_rdy   (rs_rdy),
        .rs_data  (rs_data)
    );

    rx_commit_fifo #(.DW(DW), .DEPTH(LOC_DEPTH)) u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (loc_push),
        .push_data(lnk_data),
        .push_last(lnk_last),
        .drop     (loc_drop),
        .full     (loc_full),
        .pop      (loc_rdy),
        .out_vld  (loc_vld),
        .out_data (loc_data),
        .out_last (loc_last)
    );

    rx_plain_fifo #(.DW(DW), .DEPTH(BYP_DEPTH)) u_byp (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (byp_push),
        .push_data(lnk_data),
        .push_last(lnk_last),
        .full     (byp_full),
        .pop      (byp_rdy),
        .out_vld  (byp_vld),
        .out_data (byp_data),
        .out_last (byp_last)
    );

    a_r8_blocked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_vld && !lnk_rdy) |-> (!loc_push && !byp_push && !loc_drop));

endmodule

// File: tb/rx_filter_stage_bench.sv
module rx_filter_stage_bench;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int LD = 8;
    localparam int BD = 4;
    localparam logic [3:0] NODE = 4'h5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lnk_vld = 1'b0, lnk_last = 1'b0, lnk_rdy;
    logic [DW-1:0] lnk_data = '0;
    logic          loc_vld, loc_last, loc_rdy = 1'b0;
    logic [DW-1:0] loc_data;
    logic          byp_vld, byp_last, byp_rdy = 1'b0;
    logic [DW-1:0] byp_data;
    logic          rs_vld, rs_rdy = 1'b0;
    logic [DW-1:0] rs_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [16:0] expq [32];
    int          expn;
    logic [16:0] got  [32];
    int          gotn;

    always #4 clk = ~clk;

    rx_filter_stage #(.DW(DW), .AW(AW), .OPW(2), .LOC_DEPTH(LD), .BYP_DEPTH(BD)) u_rx_filter_stage (
        .clk(clk), .rst_n(rst_n), .node_addr(NODE),
        .lnk_vld(lnk_vld), .lnk_rdy(lnk_rdy), .lnk_data(lnk_data), .lnk_last(lnk_last),
        .loc_vld(loc_vld), .loc_rdy(loc_rdy), .loc_data(loc_data), .loc_last(loc_last),
        .byp_vld(byp_vld), .byp_rdy(byp_rdy), .byp_data(byp_data), .byp_last(byp_last),
        .rs_vld(rs_vld), .rs_rdy(rs_rdy), .rs_data(rs_data)
    );

    function automatic logic [15:0] hdr(input logic [3:0] d, input logic [3:0] s,
                                        input logic [1:0] op, input logic [5:0] tag);
        return {d, s, op, tag};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lnk_vld = 1'b0; loc_rdy = 1'b0; byp_rdy = 1'b0; rs_rdy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, input logic last);
        lnk_data = w; lnk_last = last; lnk_vld = 1'b1;
        while (!lnk_rdy) @(negedge clk);
        @(posedge clk);
        #1 lnk_vld = 1'b0;
    endtask

    task automatic drain_loc(input int cycles);
        gotn = 0;
        @(negedge clk);
        loc_rdy = 1'b1;
        for (int k = 0; k < cycles; k++) begin
            if (loc_vld) begin
                got[gotn] = {loc_last, loc_data};
                gotn++;
            end
            @(negedge clk);
        end
        loc_rdy = 1'b0;
    endtask

    task automatic catch_rs(output bit found, output logic [15:0] w);
        found = 1'b0; w = '0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (rs_vld) begin
                found = 1'b1; w = rs_data; rs_rdy = 1'b1;
                @(negedge clk);
                rs_rdy = 1'b0;
                break;
            end
        end
    endtask

    task automatic compare_loc(input string req);
        check(gotn == expn, req, "local word count", gotn, expn);
        for (int k = 0; k < expn && k < gotn; k++)
            check(got[k] == expq[k], req, "local word", int'(got[k]), int'(expq[k]));
    endtask

    task automatic prefill(input int p);
        for (int i = 0; i < p; i++) begin
            send(hdr(NODE, 4'h1, 2'b00, 6'(i)), 1'b1);
            expq[expn] = {1'b1, hdr(NODE, 4'h1, 2'b00, 6'(i))};
            expn++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit found;
        logic [15:0] rw;
        logic [15:0] w;

        // R9: reset state
        do_reset();
        check(lnk_rdy == 1'b1, "R9", "lnk_rdy", lnk_rdy, 1);
        check(loc_vld == 1'b0, "R9", "loc_vld", loc_vld, 0);
        check(byp_vld == 1'b0, "R9", "byp_vld", byp_vld, 0);
        check(rs_vld == 1'b0, "R9", "rs_vld", rs_vld, 0);

        // R1 R3 R4 R5 R6: sweep start occupancy p and packet length L
        for (int p = 0; p <= LD; p++) begin
            for (int L = 1; L <= LD + 1; L++) begin
                bit fits;
                do_reset();
                expn = 0;
                prefill(p);
                fits = (p + L) <= LD;
                fork
                    begin
                        for (int j = 0; j < L; j++) begin
                            w = (j == 0) ? hdr(NODE, 4'hA, 2'b00, 6'(p*10 + L))
                                         : 16'(16'h3000 + j*7);
                            send(w, j == L-1);
                            if (fits) begin
                                expq[expn] = {j == L-1, w};
                                expn++;
                            end
                            if (p == 0 && L >= 2 && j == L-2)
                                check(loc_vld == 1'b0, "R3", "loc_vld before last word", loc_vld, 0);
                        end
                    end
                    catch_rs(found, rw);
                join
                check(found == !fits, "R4", "resend produced", found, !fits);
                if (found)
                    check(rw == hdr(4'hA, NODE, 2'b11, 6'h0), "R6", "resend word", rw,
                          hdr(4'hA, NODE, 2'b11, 6'h0));
                if (!fits && p < LD) begin
                    // R5: the next word must be decoded as a header again
                    send(hdr(NODE, 4'h2, 2'b00, 6'h3F), 1'b1);
                    expq[expn] = {1'b1, hdr(NODE, 4'h2, 2'b00, 6'h3F)};
                    expn++;
                    @(negedge clk);
                    check(byp_vld == 1'b0, "R5", "byp_vld after discard", byp_vld, 0);
                end
                drain_loc(LD + 4);
                compare_loc(fits ? "R1" : "R4");
            end
        end

        // R2 R8: forwarding path, payload that looks local, full forwarding buffer
        do_reset();
        send(hdr(4'h7, 4'h3, 2'b00, 6'h01), 1'b0);
        send(hdr(NODE, 4'h3, 2'b00, 6'h02), 1'b1);
        send(hdr(4'h9, 4'h3, 2'b00, 6'h03), 1'b1);
        send(hdr(4'h0, 4'h3, 2'b00, 6'h04), 1'b1);
        @(negedge clk);
        check(lnk_rdy == 1'b0, "R8", "lnk_rdy with forwarding buffer full", lnk_rdy, 0);
        check(loc_vld == 1'b0, "R2", "loc_vld for forwarded traffic", loc_vld, 0);
        lnk_data = hdr(NODE, 4'h4, 2'b00, 6'h05); lnk_last = 1'b1; lnk_vld = 1'b1;
        repeat (3) @(negedge clk);
        lnk_vld = 1'b0;
        check(loc_vld == 1'b0, "R8", "word taken while lnk_rdy low", loc_vld, 0);
        byp_rdy = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic [16:0] e;
            unique case (k)
                0: e = {1'b0, hdr(4'h7, 4'h3, 2'b00, 6'h01)};
                1: e = {1'b1, hdr(NODE, 4'h3, 2'b00, 6'h02)};
                2: e = {1'b1, hdr(4'h9, 4'h3, 2'b00, 6'h03)};
                default: e = {1'b1, hdr(4'h0, 4'h3, 2'b00, 6'h04)};
            endcase
            check(byp_vld == 1'b1, "R2", "byp_vld", byp_vld, 1);
            check({byp_last, byp_data} == e, "R2", "forwarded word", int'({byp_last, byp_data}), int'(e));
            @(negedge clk);
        end
        check(byp_vld == 1'b0, "R2", "forwarding buffer empty", byp_vld, 0);
        byp_rdy = 1'b0;

        // R7: overflowing resend-request packet gets no resend
        do_reset();
        expn = 0;
        prefill(LD);
        fork
            send(hdr(NODE, 4'hC, 2'b11, 6'h00), 1'b1);
            catch_rs(found, rw);
        join
        check(found == 1'b0, "R7", "resend for resend-request packet", found, 0);
        check(lnk_rdy == 1'b1, "R7", "lnk_rdy after silent drop", lnk_rdy, 1);
        drain_loc(LD + 4);
        compare_loc("R7");

        // R8 R6: pending resend blocks the link until taken
        do_reset();
        expn = 0;
        prefill(LD);
        send(hdr(NODE, 4'hD, 2'b00, 6'h11), 1'b1);
        @(negedge clk);
        check(rs_vld == 1'b1, "R6", "rs_vld after overflow", rs_vld, 1);
        check(rs_data == hdr(4'hD, NODE, 2'b11, 6'h0), "R6", "resend word", rs_data,
              hdr(4'hD, NODE, 2'b11, 6'h0));
        check(lnk_rdy == 1'b0, "R8", "lnk_rdy with resend pending", lnk_rdy, 0);
        repeat (2) @(negedge clk);
        check(rs_vld == 1'b1, "R6", "resend held", rs_vld, 1);
        rs_rdy = 1'b1;
        @(negedge clk);
        rs_rdy = 1'b0;
        check(lnk_rdy == 1'b1, "R8", "lnk_rdy after resend taken", lnk_rdy, 1);
        check(rs_vld == 1'b0, "R6", "rs_vld after taken", rs_vld, 0);

        // R10: read from a full buffer in the same cycle as a local header
        do_reset();
        expn = 0;
        prefill(LD);
        @(negedge clk);
        loc_rdy = 1'b1;
        lnk_data = hdr(NODE, 4'hB, 2'b00, 6'h22); lnk_last = 1'b0; lnk_vld = 1'b1;
        check(lnk_rdy == 1'b1, "R10", "lnk_rdy at collision", lnk_rdy, 1);
        @(posedge clk);
        #1 loc_rdy = 1'b0; lnk_vld = 1'b0;
        fork
            send(16'h3123, 1'b1);
            catch_rs(found, rw);
        join
        check(found == 1'b1, "R10", "resend after collision", found, 1);
        check(rw == hdr(4'hB, NODE, 2'b11, 6'h0), "R10", "resend word", rw,
              hdr(4'hB, NODE, 2'b11, 6'h0));
        for (int k = 0; k < LD - 1; k++) expq[k] = expq[k+1];
        expn = LD - 1;
        drain_loc(LD + 4);
        compare_loc("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule